// File: doc/BRIEF.md
# DMA Request Line Router

This block sits between a large set of peripheral request lines and a small bank of DMA channels. Software programs one map entry per request line. Each entry carries an enable bit and the number of the channel that the line should drive. On every clock the router gathers the live request lines into one request level per channel. It registers that level and marks its edges: a one-cycle arrival event when a channel's request becomes active, and a one-cycle end-of-receive event when it goes away. The channel status logic downstream consumes these.

The map entries sit in two windows of a word-addressed register space. The first window holds the low entries and a second, higher window holds the rest. A write that enables an entry but names a channel that does not exist is refused: the entry keeps its old contents and an error pulse is raised. Channel arbitration and data movement are handled elsewhere.

Top module: `dmarq_mapper`

## Requirements
- R1: After reset every map entry reads 0x00, every channel request level is 0, and no event or error pulse is high.
- R2: Entry i (0 to 63) sits at word address 0x040+i and entry i (64 to 74) at word address 0x440+(i-64). Any other address reads 0x00, and writes to it change no entry and raise no error.
- R3: An entry reads back as bit 7 = enable and bits 4:0 = channel number. Bits 6:5 always read as 0, whatever was written to them.
- R4: A request line whose entry has the enable bit clear has no effect on any channel request level or event.
- R5: A channel's request level equals the OR of all live request lines whose enabled entries name that channel, one clock after the lines are sampled.
- R6: When a channel's request level goes from 0 to 1, that channel's arrival event is high for exactly that one cycle. Otherwise it is low.
- R7: When a channel's request level goes from 1 to 0, that channel's end-of-receive event is high for exactly that one cycle. Otherwise it is low.
- R8: A write with bit 7 set and a channel number of NUM_CH or more leaves the addressed entry unchanged and makes the error pulse high for one cycle after the write edge. The same channel number written with bit 7 clear is stored and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Word address of a map entry |
| regWrEn | input | 1 | Write strobe for the addressed entry |
| regWrData | input | 8 | Write data: bit 7 enable, bits 4:0 channel |
| regRdData | output | 8 | Combinational read of the addressed entry |
| reqIn | input | NUM_REQ | Peripheral request lines, level sensitive |
| chReq | output | NUM_CH | Registered request level per channel |
| chRasEvt | output | NUM_CH | One-cycle arrival event per channel |
| chEorEvt | output | NUM_CH | One-cycle end-of-receive event per channel |
| mapErr | output | 1 | One-cycle pulse after a refused map write |

## Verification
The bound checker watches three things on every cycle. Each event vector must equal the edge of the channel level, found by comparing it with the previous cycle's level. The channel levels must be all zero whenever the request lines were all zero one cycle earlier. An error pulse may only follow an enabled write that names a channel out of range. Other behaviours only show up in the bench's scenarios: which channel a given line drives, the OR of two lines that share a channel, the silence of a disabled line, the placement of the two address windows, and the fact that a refused write leaves the entry as it was.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  // Field layout of one map entry; downstream decoding depends on these positions.
  localparam int CH_FIELD_W = 5;
  localparam int EN_BIT     = 7;
  localparam int WORD_W     = 8;
  // Index width supports up to 128 request lines.
  localparam int IDX_W      = 7;

  typedef struct packed {
    logic                  hit;     // address decodes to an entry
    logic [IDX_W-1:0]      idx;     // entry index
    logic                  wrMap;   // accepted write this cycle
    logic                  wrErr;   // refused write this cycle
    logic                  en;      // enable bit to store
    logic [CH_FIELD_W-1:0] chan;    // channel number to store
  } mapStrobe_t;
endpackage

// File: rtl/dmarq_ctrl.sv
module dmarq_ctrl
  import dmarq_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_BASE = 12'h040,
  parameter logic [ADDR_W-1:0] HI_BASE = 12'h440
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output mapStrobe_t        stb
);
  localparam int LO_CNT = (NUM_REQ < 64) ? NUM_REQ : 64;
  localparam int HI_CNT = NUM_REQ - LO_CNT;
  localparam logic [ADDR_W-1:0] LO_END = LO_BASE + ADDR_W'(LO_CNT);
  localparam logic [ADDR_W-1:0] HI_END = HI_BASE + ADDR_W'(HI_CNT);

  logic hitLo, hitHi, badChan;

  assign hitLo = (regAddr >= LO_BASE) && (regAddr < LO_END);
  assign hitHi = (HI_CNT > 0) && (regAddr >= HI_BASE) && (regAddr < HI_END);
  assign badChan = regWrData[EN_BIT] &&
                   ({1'b0, regWrData[CH_FIELD_W-1:0]} >= (CH_FIELD_W+1)'(NUM_CH));

  always_comb begin
    stb.hit = hitLo || hitHi;
    if (hitLo)      stb.idx = IDX_W'(regAddr - LO_BASE);
    else if (hitHi) stb.idx = IDX_W'(regAddr - HI_BASE) + IDX_W'(LO_CNT);
    else            stb.idx = '0;
    stb.wrMap = regWrEn && stb.hit && !badChan;
    stb.wrErr = regWrEn && stb.hit && badChan;
    stb.en    = regWrData[EN_BIT];
    stb.chan  = regWrData[CH_FIELD_W-1:0];
  end
endmodule

// File: rtl/dmarq_datapath.sv
module dmarq_datapath
  import dmarq_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobe_t         stb,
  input  logic [NUM_REQ-1:0] reqIn,
  output logic [WORD_W-1:0]  rdData,
  output logic [NUM_CH-1:0]  chReq,
  output logic [NUM_CH-1:0]  chRasEvt,
  output logic [NUM_CH-1:0]  chEorEvt,
  output logic               mapErr
);
  logic [NUM_CH-1:0] lineOneHot [NUM_REQ];
  logic [WORD_W-1:0] lineWord   [NUM_REQ];
  logic [NUM_CH-1:0] chNext;

  for (genvar r = 0; r < NUM_REQ; r++) begin : gLine
    logic                  en;
    logic [CH_FIELD_W-1:0] ch;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0;
        ch <= '0;
      end else if (stb.wrMap && (stb.idx == IDX_W'(r))) begin
        en <= stb.en;
        ch <= stb.chan;
      end
    end
    // Only enabled entries drive a channel; enabled entries always hold a legal channel.
    assign lineOneHot[r] = (en && reqIn[r]) ? (NUM_CH'(1) << ch) : '0;
    assign lineWord[r]   = {en, {(WORD_W-CH_FIELD_W-1){1'b0}}, ch};
  end

  always_comb begin
    chNext = '0;
    for (int r = 0; r < NUM_REQ; r++) chNext = chNext | lineOneHot[r];
  end

  always_comb begin
    rdData = '0;
    for (int r = 0; r < NUM_REQ; r++)
      if (stb.hit && (stb.idx == IDX_W'(r))) rdData = lineWord[r];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chReq    <= '0;
      chRasEvt <= '0;
      chEorEvt <= '0;
      mapErr   <= 1'b0;
    end else begin
      chReq    <= chNext;
      chRasEvt <= chNext & ~chReq;
      chEorEvt <= ~chNext & chReq;
      mapErr   <= stb.wrErr;
    end
  end
endmodule

// File: rtl/dmarq_mapper.sv
module dmarq_mapper
  import dmarq_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic [NUM_REQ-1:0] reqIn,
  output logic [NUM_CH-1:0]  chReq,
  output logic [NUM_CH-1:0]  chRasEvt,
  output logic [NUM_CH-1:0]  chEorEvt,
  output logic               mapErr
);
  mapStrobe_t stb;

  dmarq_ctrl #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uCtrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .stb      (stb)
  );

  dmarq_datapath #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqIn   (reqIn),
    .rdData  (regRdData),
    .chReq   (chReq),
    .chRasEvt(chRasEvt),
    .chEorEvt(chEorEvt),
    .mapErr  (mapErr)
  );
endmodule

// File: rtl/dmarq_mapper_chk.sv
module dmarq_mapper_chk #(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [7:0]         regWrData,
  input logic [7:0]         regRdData,
  input logic [NUM_REQ-1:0] reqIn,
  input logic [NUM_CH-1:0]  chReq,
  input logic [NUM_CH-1:0]  chRasEvt,
  input logic [NUM_CH-1:0]  chEorEvt,
  input logic               mapErr
);
  // R6
  ras_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    chRasEvt == (chReq & ~$past(chReq)));

  // R7
  eor_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    chEorEvt == ($past(chReq) & ~chReq));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqIn) == '0) |-> (chReq == '0));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapErr |-> ($past(regWrEn) && $past(regWrData[7]) &&
                ({1'b0, $past(regWrData[4:0])} >= 6'(NUM_CH))));
endmodule

bind dmarq_mapper dmarq_mapper_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_dmarq_mapper.sv
`timescale 1ns/1ps
module tb_dmarq_mapper;
  localparam int NUM_REQ = 75;
  localparam int NUM_CH  = 16;
  localparam int ADDR_W  = 12;
  localparam int VEC_W   = NUM_REQ + 3*NUM_CH;
  localparam int NVEC    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [NUM_REQ-1:0] reqIn = '0;
  logic [NUM_CH-1:0] chReq, chRasEvt, chEorEvt;
  logic mapErr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmarq_mapper #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (.*);

  // {reqIn, expected level, expected arrival, expected end-of-receive}
  // Map: line0->ch0, line1->ch1, line5->ch1, line10 disabled ch2, line64->ch3, line74->ch15
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {75'h001, 16'h0001, 16'h0001, 16'h0000},   // R5 R6 first arrival
    {75'h001, 16'h0001, 16'h0000, 16'h0000},   // R6 held level, no repeat
    {75'h002, 16'h0002, 16'h0002, 16'h0001},   // R6 R7 hand over channel
    {75'h022, 16'h0002, 16'h0000, 16'h0000},   // R5 two lines OR into ch1
    {75'h020, 16'h0002, 16'h0000, 16'h0000},   // R5 one of two drops, level kept
    {75'h400, 16'h0000, 16'h0000, 16'h0002},   // R4 disabled line ignored
    {(75'd1 << 64) | (75'd1 << 74), 16'h8008, 16'h8008, 16'h0000}, // R2 high window
    {75'h000, 16'h0000, 16'h0000, 16'h8008}    // R7 release
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d, output logic errSeen);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    errSeen = mapErr;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic e;
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 level", 32'(chReq), 0);
    chk("R1 events", 32'(chRasEvt | chEorEvt), 0);
    chk("R1 err", 32'(mapErr), 0);
    @(negedge clk); rstN = 1'b1;
    rd(12'h040, d); chk("R1 entry0", 32'(d), 0);
    rd(12'h44A, d); chk("R1 entry74", 32'(d), 0);

    wr(12'h040, 8'h80, e); chk("R8 legal no err", 32'(e), 0);
    wr(12'h041, 8'h81, e);
    wr(12'h045, 8'hE1, e);
    wr(12'h04A, 8'h02, e);
    wr(12'h440, 8'h83, e);
    wr(12'h44A, 8'h8F, e);
    rd(12'h045, d); chk("R3 bits 6:5 zero", 32'(d), 32'h81);
    rd(12'h440, d); chk("R2 entry64", 32'(d), 32'h83);
    rd(12'h44A, d); chk("R2 entry74", 32'(d), 32'h8F);

    foreach (VEC[i]) begin
      @(negedge clk);
      reqIn = VEC[i][VEC_W-1 -: NUM_REQ];
      @(posedge clk); #1;
      chk($sformatf("R5 level vec%0d", i), 32'(chReq), 32'(VEC[i][3*NUM_CH-1 -: NUM_CH]));
      chk($sformatf("R6 arrival vec%0d", i), 32'(chRasEvt), 32'(VEC[i][2*NUM_CH-1 -: NUM_CH]));
      chk($sformatf("R7 eor vec%0d", i), 32'(chEorEvt), 32'(VEC[i][NUM_CH-1:0]));
    end

    // R8 out-of-range channel refused
    wr(12'h046, 8'h90, e); chk("R8 err pulse", 32'(e), 1);
    @(posedge clk); #1; chk("R8 err one cycle", 32'(mapErr), 0);
    rd(12'h046, d); chk("R8 not stored", 32'(d), 0);
    wr(12'h041, 8'h9F, e); chk("R8 err on used entry", 32'(e), 1);
    rd(12'h041, d); chk("R8 entry kept", 32'(d), 32'h81);
    wr(12'h047, 8'h1F, e); chk("R8 disabled no err", 32'(e), 0);
    rd(12'h047, d); chk("R8 disabled stored", 32'(d), 32'h1F);
    // R4 disabled entry with large channel drives nothing
    @(negedge clk); reqIn = 75'h080;
    @(posedge clk); #1; chk("R4 disabled line", 32'(chReq | chRasEvt), 0);
    @(negedge clk); reqIn = '0;

    // R2 unmapped addresses
    wr(12'h080, 8'h81, e); chk("R2 gap write no err", 32'(e), 0);
    rd(12'h080, d); chk("R2 gap reads zero", 32'(d), 0);
    rd(12'h44B, d); chk("R2 past last entry", 32'(d), 0);
    wr(12'h03F, 8'h85, e); rd(12'h03F, d); chk("R2 below window", 32'(d), 0);

    // R1 reset clears map again
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rstN = 1'b1;
    rd(12'h041, d); chk("R1 map cleared", 32'(d), 0);
    @(negedge clk); reqIn = 75'h002;
    @(posedge clk); #1; chk("R1 unmapped after reset", 32'(chReq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule